// File: doc/BRIEF.md
# Touch-Sensor Telemetry Frame Serializer

The block sends a fixed-length diagnostic frame out of a capacitive key sensor after each acquisition cycle. A one-cycle start strobe freezes a snapshot of the sensing state. That snapshot holds a running frame number, a version byte, per-key baseline words, raw measurement words, signed difference words, two flag bytes and a packed status byte. The block then shifts the snapshot out on a clock line and a data line that it drives itself. Between frames both lines are released: their output enables are low, so an external pad or bus can leave them floating.

Each word leaves low byte first. The frame number appears at both ends of the frame so that a receiver can spot a torn capture. Bits go out most significant first. The data line changes only while the serial clock is low, and a receiver samples it on the rising edge of the serial clock. An idle gap separates consecutive bytes. The half-bit length and the gap length are given in core clock cycles. The key count and the word width are also parameters. With the default of four keys and 16-bit words, a frame is 30 bytes long.

Top module: `tlm_frame_serializer`

## Requirements
- R1: After reset both output enables are low, the serial clock and data outputs are low, and the first frame carries frame number 0.
- R2: A start strobe seen while idle raises both output enables at the next clock edge. They stay high until the last bit's high phase ends, then both drop together.
- R3: A frame holds 6*NUM_KEYS+6 bytes, which is 30 with the defaults. Its first and last bytes both carry an 8-bit frame number that rises by one per frame and wraps from 255 to 0.
- R4: Byte 1 carries the version input unchanged: major revision in bits 7:4, minor revision in bits 3:0.
- R5: Bytes 2 to 9 carry the baseline words of keys 0 to 3. Bytes 10 to 17 carry the raw measurement words and bytes 18 to 25 the two's-complement difference words. Each word goes low byte first and in key order.
- R6: Byte 26 is flag byte A and byte 27 is flag byte B. Byte 28 is the status byte: bit 7 is the calibration flag, bits 6:4 the active key count and bit k (bits 3:0) the touch state of key k.
- R7: Bits leave most significant first. The data line holds its value while the serial clock is high and changes only while it is low. The serial clock is low in the first driven cycle and stays low while the lines are released.
- R8: Within a byte, the serial clock is low for HALF_CYC cycles and then high for HALF_CYC cycles per bit, so its rising edges are 2*HALF_CYC cycles apart.
- R9: The first rising edges of consecutive bytes are 16*HALF_CYC+GAP_CYC cycles apart. The serial clock stays low during the gap.
- R10: A start strobe during a frame is ignored: the frame completes unchanged, no second frame follows it, and input changes after the strobe that started it do not reach the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start strobe |
| ref_i | input | NUM_KEYS*WORD_W | Baseline word per key, key 0 in the low bits |
| sig_i | input | NUM_KEYS*WORD_W | Raw measurement word per key |
| dlt_i | input | NUM_KEYS*WORD_W | Signed difference word per key |
| flg_a_i | input | 8 | Flag byte A |
| flg_b_i | input | 8 | Flag byte B |
| touch_i | input | NUM_KEYS | Touch state per key |
| kcnt_i | input | 3 | Active key count |
| cal_i | input | 1 | Calibration in progress |
| ver_i | input | 8 | Version byte |
| ser_clk_o | output | 1 | Serial clock value |
| ser_dat_o | output | 1 | Serial data value |
| ser_clk_oe_o | output | 1 | Serial clock output enable |
| ser_dat_oe_o | output | 1 | Serial data output enable |

## Verification
Some properties are checked on every cycle: the data line holds while the serial clock is high, the clock stays low while released, a strobe mid-frame does not stop the frame, the byte index only advances one step at a time, the frame number steps by one at each frame end, and the snapshot is frozen while busy. Byte contents, field order, the frame number wrap after 256 frames, the bit and byte spacing, and the absence of a queued frame after an ignored strobe come from the bench. It decodes every frame at the pins and compares each one with bytes computed from its own inputs.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2,
      PH_GAP  = 2'd3
   } phase_e;

   localparam int STATUS_TOUCH_BITS = 4;
   localparam int KCNT_W            = 3;

   // header (number, version) + three word groups + flags A/B + status + trailer number
   function automatic int frame_len(input int keys, input int word_bytes);
      return 2 + 3 * keys * word_bytes + 4;
   endfunction

endpackage

// File: rtl/tlm_snapshot.sv
module tlm_snapshot
   import tlm_pkg::*;
#(
   parameter int NUM_KEYS = 4,
   parameter int WORD_W   = 16,
   localparam int WB      = WORD_W / 8,
   localparam int NB      = frame_len(NUM_KEYS, WB),
   localparam int SEL_W   = $clog2(NB),
   localparam int KW      = NUM_KEYS * WORD_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture_i,
   input  logic                done_i,
   input  logic                busy_i,
   input  logic [KW-1:0]       ref_i,
   input  logic [KW-1:0]       sig_i,
   input  logic [KW-1:0]       dlt_i,
   input  logic [7:0]          flg_a_i,
   input  logic [7:0]          flg_b_i,
   input  logic [NUM_KEYS-1:0] touch_i,
   input  logic [KCNT_W-1:0]   kcnt_i,
   input  logic                cal_i,
   input  logic [7:0]          ver_i,
   input  logic [SEL_W-1:0]    sel_i,
   output logic [7:0]          byte_o
);

   localparam int IMG_W    = NB * 8;
   localparam int BASE_REF = 2;
   localparam int BASE_SIG = BASE_REF + NUM_KEYS * WB;
   localparam int BASE_DLT = BASE_SIG + NUM_KEYS * WB;
   localparam int BASE_FLG = BASE_DLT + NUM_KEYS * WB;
   localparam int IDX_STS  = BASE_FLG + 2;
   localparam int IDX_TRL  = IDX_STS + 1;

   if (WORD_W < 8 || (WORD_W % 8) != 0) begin : g_bad_word
      $error("tlm_snapshot: WORD_W must be a positive multiple of 8");
   end
   if (NUM_KEYS < 1 || NUM_KEYS > STATUS_TOUCH_BITS) begin : g_bad_keys
      $error("tlm_snapshot: NUM_KEYS must lie in 1..4");
   end

   logic [7:0]                   frm_q;
   logic [IMG_W-1:0]             img_d;
   logic [IMG_W-1:0]             img_q;
   logic [STATUS_TOUCH_BITS-1:0] touch_pad;

   // touch field padding variant
   if (NUM_KEYS == STATUS_TOUCH_BITS) begin : g_touch_full
      assign touch_pad = touch_i;
   end else begin : g_touch_pad
      assign touch_pad = {{(STATUS_TOUCH_BITS - NUM_KEYS){1'b0}}, touch_i};
   end

   // frame image assembly
   assign img_d[0 +: 8]              = frm_q;
   assign img_d[8 +: 8]              = ver_i;
   assign img_d[BASE_FLG*8 +: 8]     = flg_a_i;
   assign img_d[(BASE_FLG+1)*8 +: 8] = flg_b_i;
   assign img_d[IDX_STS*8 +: 8]      = {cal_i, kcnt_i, touch_pad};
   assign img_d[IDX_TRL*8 +: 8]      = frm_q;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      for (genvar b = 0; b < WB; b++) begin : g_lane
         assign img_d[(BASE_REF + k*WB + b)*8 +: 8] = ref_i[k*WORD_W + b*8 +: 8];
         assign img_d[(BASE_SIG + k*WB + b)*8 +: 8] = sig_i[k*WORD_W + b*8 +: 8];
         assign img_d[(BASE_DLT + k*WB + b)*8 +: 8] = dlt_i[k*WORD_W + b*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         img_q <= '0;
      end else if (capture_i) begin
         img_q <= img_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_q <= 8'd0;
      end else if (done_i) begin
         frm_q <= frm_q + 8'd1;
      end
   end

   assign byte_o = img_q[{sel_i, 3'b000} +: 8];

   a_r3_number_step: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> (frm_q == $past(frm_q) + 8'd1));

   a_r10_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !capture_i) |=> $stable(img_q));

endmodule

// File: rtl/tlm_bit_sequencer.sv
module tlm_bit_sequencer
   import tlm_pkg::*;
#(
   parameter int HALF_CYC = 4,
   parameter int GAP_CYC  = 8,
   parameter int NBYTES   = 30,
   localparam int SEL_W   = $clog2(NBYTES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             capture_o,
   output logic             done_o,
   output logic             busy_o,
   output logic             line_clk_o,
   output logic [2:0]       bit_o,
   output logic [SEL_W-1:0] byte_o
);

   localparam int MAXC = (HALF_CYC > GAP_CYC) ? HALF_CYC : ((GAP_CYC > 0) ? GAP_CYC : 1);
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0]    HALF_LAST = CW'(HALF_CYC - 1);
   localparam logic [CW-1:0]    GAP_LAST  = CW'((GAP_CYC > 0) ? GAP_CYC - 1 : 0);
   localparam logic [SEL_W-1:0] BYTE_LAST = SEL_W'(NBYTES - 1);

   if (HALF_CYC < 1) begin : g_bad_half
      $error("tlm_bit_sequencer: HALF_CYC must be at least 1");
   end
   if (GAP_CYC < 0) begin : g_bad_gap
      $error("tlm_bit_sequencer: GAP_CYC must not be negative");
   end
   if (NBYTES < 2) begin : g_bad_len
      $error("tlm_bit_sequencer: NBYTES must be at least 2");
   end

   phase_e           ph_q, ph_d;
   logic [CW-1:0]    cnt_q, cnt_d;
   logic [2:0]       bit_q, bit_d;
   logic [SEL_W-1:0] byte_q, byte_d;
   logic             gap_en;
   logic             half_end;

   // inter-byte gap variant
   if (GAP_CYC == 0) begin : g_no_gap
      assign gap_en = 1'b0;
   end else begin : g_gap
      assign gap_en = 1'b1;
   end

   assign half_end = (cnt_q == HALF_LAST);

   always_comb begin
      ph_d   = ph_q;
      cnt_d  = cnt_q;
      bit_d  = bit_q;
      byte_d = byte_q;
      unique case (ph_q)
         PH_IDLE: begin
            if (start_i) begin
               ph_d   = PH_LOW;
               cnt_d  = '0;
               bit_d  = 3'd7;
               byte_d = '0;
            end
         end
         PH_LOW: begin
            if (half_end) begin
               ph_d  = PH_HIGH;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_HIGH: begin
            if (half_end) begin
               cnt_d = '0;
               if (bit_q != 3'd0) begin
                  bit_d = bit_q - 3'd1;
                  ph_d  = PH_LOW;
               end else if (byte_q == BYTE_LAST) begin
                  ph_d = PH_IDLE;
               end else if (gap_en) begin
                  ph_d = PH_GAP;
               end else begin
                  byte_d = byte_q + 1'b1;
                  bit_d  = 3'd7;
                  ph_d   = PH_LOW;
               end
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_GAP: begin
            if (cnt_q == GAP_LAST) begin
               cnt_d  = '0;
               byte_d = byte_q + 1'b1;
               bit_d  = 3'd7;
               ph_d   = PH_LOW;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         bit_q  <= 3'd7;
         byte_q <= '0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         bit_q  <= bit_d;
         byte_q <= byte_d;
      end
   end

   assign capture_o  = (ph_q == PH_IDLE) && start_i;
   assign done_o     = (ph_q == PH_HIGH) && half_end && (bit_q == 3'd0) && (byte_q == BYTE_LAST);
   assign busy_o     = (ph_q != PH_IDLE);
   assign line_clk_o = (ph_q == PH_HIGH);
   assign bit_o      = bit_q;
   assign byte_o     = byte_q;

   a_r7_clk_low_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !line_clk_o);

   a_r9_byte_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && !$stable(byte_q)) |-> (byte_q == $past(byte_q) + 1'b1));

   a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_LOW || ph_q == PH_HIGH) |-> (cnt_q <= HALF_LAST));

endmodule

// File: rtl/tlm_frame_serializer.sv
module tlm_frame_serializer
   import tlm_pkg::*;
#(
   parameter int NUM_KEYS = 4,
   parameter int WORD_W   = 16,
   parameter int HALF_CYC = 4,
   parameter int GAP_CYC  = 8,
   localparam int KW      = NUM_KEYS * WORD_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [KW-1:0]       ref_i,
   input  logic [KW-1:0]       sig_i,
   input  logic [KW-1:0]       dlt_i,
   input  logic [7:0]          flg_a_i,
   input  logic [7:0]          flg_b_i,
   input  logic [NUM_KEYS-1:0] touch_i,
   input  logic [2:0]          kcnt_i,
   input  logic                cal_i,
   input  logic [7:0]          ver_i,
   output logic                ser_clk_o,
   output logic                ser_dat_o,
   output logic                ser_clk_oe_o,
   output logic                ser_dat_oe_o
);

   localparam int NB    = frame_len(NUM_KEYS, WORD_W / 8);
   localparam int SEL_W = $clog2(NB);

   logic             capture;
   logic             done;
   logic             busy;
   logic             line_clk;
   logic [2:0]       bit_idx;
   logic [SEL_W-1:0] byte_idx;
   logic [7:0]       cur_byte;

   tlm_bit_sequencer #(
      .HALF_CYC (HALF_CYC),
      .GAP_CYC  (GAP_CYC),
      .NBYTES   (NB)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .capture_o  (capture),
      .done_o     (done),
      .busy_o     (busy),
      .line_clk_o (line_clk),
      .bit_o      (bit_idx),
      .byte_o     (byte_idx)
   );

   tlm_snapshot #(
      .NUM_KEYS (NUM_KEYS),
      .WORD_W   (WORD_W)
   ) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .done_i    (done),
      .busy_i    (busy),
      .ref_i     (ref_i),
      .sig_i     (sig_i),
      .dlt_i     (dlt_i),
      .flg_a_i   (flg_a_i),
      .flg_b_i   (flg_b_i),
      .touch_i   (touch_i),
      .kcnt_i    (kcnt_i),
      .cal_i     (cal_i),
      .ver_i     (ver_i),
      .sel_i     (byte_idx),
      .byte_o    (cur_byte)
   );

   assign ser_clk_o    = line_clk;
   assign ser_dat_o    = busy & cur_byte[bit_idx];
   assign ser_clk_oe_o = busy;
   assign ser_dat_oe_o = busy;

   a_r7_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk_o |-> $stable(ser_dat_o));

   a_r10_strobe_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk_oe_o && start_i && !done) |=> ser_clk_oe_o);

   a_r2_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!ser_clk_oe_o && !ser_dat_oe_o));

endmodule

// File: tb/tlm_frame_serializer_tb.sv
module tlm_frame_serializer_tb;

   localparam int H  = 1;
   localparam int G  = 1;
   localparam int NK = 4;
   localparam int NB = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [15:0] r_ref [NK];
   logic [15:0] r_sig [NK];
   logic [15:0] r_dlt [NK];
   logic [7:0]  r_fa, r_fb, r_ver;
   logic [3:0]  r_touch;
   logic [2:0]  r_kc;
   logic        r_cal;
   logic [NK*16-1:0] ref_w, sig_w, dlt_w;
   logic ser_clk, ser_dat, clk_oe, dat_oe;

   always #2 clk = ~clk;

   always_comb begin
      for (int k = 0; k < NK; k++) begin
         ref_w[k*16 +: 16] = r_ref[k];
         sig_w[k*16 +: 16] = r_sig[k];
         dlt_w[k*16 +: 16] = r_dlt[k];
      end
   end

   tlm_frame_serializer #(.NUM_KEYS(NK), .WORD_W(16), .HALF_CYC(H), .GAP_CYC(G)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .ref_i(ref_w), .sig_i(sig_w), .dlt_i(dlt_w),
      .flg_a_i(r_fa), .flg_b_i(r_fb), .touch_i(r_touch), .kcnt_i(r_kc),
      .cal_i(r_cal), .ver_i(r_ver),
      .ser_clk_o(ser_clk), .ser_dat_o(ser_dat),
      .ser_clk_oe_o(clk_oe), .ser_dat_oe_o(dat_oe));

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // pin-level decoder, sampled away from the active edge
   logic [7:0] rx [NB];
   int cyc = 0, nbits = 0, t_bit = 0, t_byte = 0;
   int bad_bit = 0, bad_byte = 0, bad_stab = 0, bad_oe = 0;
   bit frame_rdy = 1'b0;
   logic p_clk = 1'b0, p_dat = 1'b0, p_oe = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (clk_oe != dat_oe) bad_oe++;
      if (!clk_oe && ser_clk) bad_stab++;
      if (!p_oe && clk_oe) begin
         nbits = 0;
         if (ser_clk) bad_stab++;
      end
      if (clk_oe && ser_clk && !p_clk) begin
         if (ser_dat != p_dat) bad_stab++;
         if (nbits % 8 == 0) begin
            if (nbits > 0 && (cyc - t_byte) != 16*H + G) bad_byte++;
            t_byte = cyc;
         end else if ((cyc - t_bit) != 2*H) bad_bit++;
         t_bit = cyc;
         if (nbits < 8*NB) rx[nbits/8] = {rx[nbits/8][6:0], ser_dat};
         nbits++;
      end
      if (p_oe && !clk_oe) frame_rdy = 1'b1;
      p_clk = ser_clk; p_dat = ser_dat; p_oe = clk_oe;
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 190000) begin
         n_chk++; n_bad++;
         $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 190000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic load(input int s);
      for (int k = 0; k < NK; k++) begin
         r_ref[k] = 16'(s*977 + k*4099 + 300);
         r_sig[k] = 16'(s*977 + k*4099 + 300 + s*3 + k);
         r_dlt[k] = 16'(k*7 - s);
      end
      r_fa = 8'(s*5 + 1); r_fb = 8'(~s); r_ver = 8'(8'h10 + s);
      r_touch = 4'(s); r_kc = 3'(s % 5); r_cal = s[4];
   endtask

   logic [7:0] ex [NB];

   task automatic build_exp(input int num);
      ex[0] = 8'(num); ex[29] = 8'(num); ex[1] = r_ver;
      for (int k = 0; k < NK; k++) begin
         ex[2+2*k]  = r_ref[k][7:0]; ex[3+2*k]  = r_ref[k][15:8];
         ex[10+2*k] = r_sig[k][7:0]; ex[11+2*k] = r_sig[k][15:8];
         ex[18+2*k] = r_dlt[k][7:0]; ex[19+2*k] = r_dlt[k][15:8];
      end
      ex[26] = r_fa; ex[27] = r_fb;
      ex[28] = {r_cal, r_kc, r_touch};
   endtask

   task automatic run_frame(input int num, input bit poke);
      int w;
      build_exp(num);
      frame_rdy = 1'b0;
      bad_bit = 0; bad_byte = 0; bad_stab = 0; bad_oe = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(clk_oe && dat_oe, "R2", "enables one cycle after start", int'(clk_oe), 1);
      if (poke) begin
         repeat (100) @(negedge clk);
         start = 1'b1; load(num + 1000);
         @(negedge clk); start = 1'b0;
         chk(clk_oe == 1'b1, "R10", "frame continues after mid-frame strobe", int'(clk_oe), 1);
      end
      w = 0;
      while (!frame_rdy && w < 3000) begin @(negedge clk); w++; end
      chk(frame_rdy, "R2", "frame release seen", int'(frame_rdy), 1);
      chk(nbits == 8*NB, "R3", "bits per frame", nbits, 8*NB);
      chk(rx[0] == ex[0] && rx[29] == ex[29], "R3", "frame number head/tail",
          int'({rx[0], rx[29]}), int'({ex[0], ex[29]}));
      chk(rx[1] == ex[1], "R4", "version byte", rx[1], ex[1]);
      for (int i = 2; i <= 25; i++)
         chk(rx[i] == ex[i], "R5", $sformatf("word byte %0d", i), rx[i], ex[i]);
      for (int i = 26; i <= 28; i++)
         chk(rx[i] == ex[i], "R6", $sformatf("flag/status byte %0d", i), rx[i], ex[i]);
      chk(bad_stab == 0, "R7", "data stability / clock idle low", bad_stab, 0);
      chk(bad_oe == 0, "R2", "enables move together", bad_oe, 0);
      chk(bad_bit == 0, "R8", "bit spacing errors", bad_bit, 0);
      chk(bad_byte == 0, "R9", "byte spacing errors", bad_byte, 0);
      if (poke) begin
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!clk_oe, "R10", "no queued frame after ignored strobe", int'(clk_oe), 0);
         end
      end
   endtask

   initial begin
      load(0);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!clk_oe && !dat_oe, "R1", "enables low in reset", int'({clk_oe, dat_oe}), 0);
      chk(!ser_clk && !ser_dat, "R1", "lines low in reset", int'({ser_clk, ser_dat}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!clk_oe && !ser_clk, "R1", "idle after reset", int'({clk_oe, ser_clk}), 0);
      // R3 sweep beyond one wrap of the frame number; R1 first frame is number 0
      for (int n = 0; n < 258; n++) begin
         load(n);
         run_frame(n, n == 5 || n == 200);
         repeat (2) @(negedge clk);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule